// File: doc/BRIEF.md
# Multi-Port GPIO Controller with Edge Interrupts

This block is a memory-mapped general-purpose I/O peripheral built from up to seven ports of eight pins each. Every port owns a bank of registers placed at a fixed stride. Software uses the bank to do the following per pin:

- set the output value, and choose one of four drive modes;
- turn the pull-up off;
- choose a single trigger edge;
- enable the interrupt;
- observe and clear latched edge events.

A test force register can inject events directly. A global control word at the bottom of the map holds a clock-request enable and a sync-select bit. It also reports the port count and a version number as read-only fields.

Pad inputs are asynchronous. A two-flop synchroniser brings them into the clock domain before they reach the input data register and the edge detector. The pad-side outputs per pin are the drive value, the driver enable and the pull-up enable. Each port drives one interrupt line: the OR of its enabled, latched events.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: Port p's bank starts at byte address p*0x30. Its registers sit at these offsets: input data 0x04, output data 0x08, drive mode 0x0C, pull-up disable 0x10, event 0x14, interrupt enable 0x18, force 0x1C, edge select 0x20. Any address outside a register, including offset 0x00 of ports above 0, reads 0. Writes to the input data register are ignored.
- R2: The drive mode of pin k is held at bits [2k+1:2k]. Code 00 is input and disables the driver. Code 01 is push-pull and always enables the driver. Code 10 is open-drain and enables the driver only while the output data bit is 0. Code 11 is open-source and enables the driver only while the output data bit is 1.
- R3: The output data bit of each pin appears on its pad drive value `pin_o` in every mode. The output data register reads back its low 8 bits.
- R4: A 1 in a pin's pull-up disable bit drives `pull_en_o` low for that pin. A 0 drives it high.
- R5: The input data register shows `pin_i` delayed by two clock edges.
- R6: An edge-select bit of 0 latches falling edges and a 1 latches rising edges. The opposite edge is ignored. The event bit is set one edge after the input data register changes, whatever the pin's interrupt enable.
- R7: Event bits are sticky. Writing 1 to an event bit clears it. Writing 0 has no effect. A new edge or a force in the same cycle wins over the clear.
- R8: `irq_o[p]` is high exactly when port p has an event bit set whose enable bit is also set. Other ports are unaffected.
- R9: Each 1 bit in a port's force register sets the matching event bit on every edge after the write. Writing 0 stops the injection.
- R10: Address 0x00 is the global control word, laid out as follows:
  - Bits 1:0 are read/write. `clk_req_o` follows bit 0.
  - Bits 8:2 read as the version parameter.
  - Bits 15:9 read as the number of ports.
  - All other bits read 0.
- R11: After reset every register is 0:
  - no driver is enabled;
  - all pull-ups are enabled;
  - all interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Byte address |
| we_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, same cycle |
| pin_i | input | NUM_PORTS*8 | Asynchronous pad inputs |
| pin_o | output | NUM_PORTS*8 | Pad drive values |
| pin_oe_o | output | NUM_PORTS*8 | Pad driver enables |
| pull_en_o | output | NUM_PORTS*8 | Pull-up enables |
| irq_o | output | NUM_PORTS | One interrupt line per port |
| clk_req_o | output | 1 | Block clock request |

## Verification
The assertions assume the bus inputs are known whenever reset is inactive. They also assume that a change to the event register is caused only by a write cycle, and never by a two-cycle access. The stimulus meets these assumptions by driving `we_i`, `addr_i` and `wdata_i` on the falling clock edge and holding `we_i` for exactly one rising edge. Pad inputs change only on falling edges and are held for at least three cycles, so the synchroniser delay seen at the ports is deterministic.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int PINS_PER_PORT = 8;
  localparam int BANK_STRIDE   = 'h30;

  localparam int OFS_CTRL  = 'h00;
  localparam int OFS_IN    = 'h04;
  localparam int OFS_OUT   = 'h08;
  localparam int OFS_MODE  = 'h0C;
  localparam int OFS_PDIS  = 'h10;
  localparam int OFS_EV    = 'h14;
  localparam int OFS_IEN   = 'h18;
  localparam int OFS_FORCE = 'h1C;
  localparam int OFS_ESEL  = 'h20;

  typedef enum logic [1:0] {
    DRV_INPUT = 2'b00,
    DRV_PUSH  = 2'b01,
    DRV_DRAIN = 2'b10,
    DRV_SRC   = 2'b11
  } drv_mode_e;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int BASE   = 0
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic                         we_i,
  input  logic [15:0]                  wdata_i,
  input  logic [PINS_PER_PORT-1:0]     pin_i,
  output logic [31:0]                  rdata_o,
  output logic [PINS_PER_PORT-1:0]     pin_o,
  output logic [PINS_PER_PORT-1:0]     pin_oe_o,
  output logic [PINS_PER_PORT-1:0]     pull_en_o,
  output logic [PINS_PER_PORT-1:0]     ev_o,
  output logic [PINS_PER_PORT-1:0]     ien_o,
  output logic [2*PINS_PER_PORT-1:0]   mode_o,
  output logic                         irq_o
);
  localparam int NP = PINS_PER_PORT;
  localparam logic [ADDR_W-1:0] BASE_A  = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] LIMIT_A = ADDR_W'(BASE + BANK_STRIDE);

  logic [NP-1:0]   dout_q, pdis_q, ev_q, ien_q, force_q, esel_q;
  logic [2*NP-1:0] mode_q;
  logic [NP-1:0]   in_sync, prev_q, hit, ev_clr;
  logic            in_bank;
  logic [ADDR_W-1:0] off;

  assign in_bank = (addr_i >= BASE_A) && (addr_i < LIMIT_A);
  assign off     = addr_i - BASE_A;

  function automatic logic sel(input logic [ADDR_W-1:0] o, input int ofs);
    return o == ADDR_W'(ofs);
  endfunction

  gpio_sync2 #(.WIDTH(NP)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (in_sync)
  );

  // Edge detect on synchronised input
  for (genvar k = 0; k < NP; k++) begin : g_edge
    assign hit[k] = esel_q[k] ? (in_sync[k] & ~prev_q[k]) : (~in_sync[k] & prev_q[k]);
  end

  assign ev_clr = (we_i && in_bank && sel(off, OFS_EV)) ? wdata_i[NP-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q  <= '0;
      pdis_q  <= '0;
      ev_q    <= '0;
      ien_q   <= '0;
      force_q <= '0;
      esel_q  <= '0;
      mode_q  <= '0;
      prev_q  <= '0;
    end else begin
      prev_q <= in_sync;
      ev_q   <= (ev_q & ~ev_clr) | hit | force_q;
      if (we_i && in_bank) begin
        if (sel(off, OFS_OUT))   dout_q  <= wdata_i[NP-1:0];
        if (sel(off, OFS_MODE))  mode_q  <= wdata_i[2*NP-1:0];
        if (sel(off, OFS_PDIS))  pdis_q  <= wdata_i[NP-1:0];
        if (sel(off, OFS_IEN))   ien_q   <= wdata_i[NP-1:0];
        if (sel(off, OFS_FORCE)) force_q <= wdata_i[NP-1:0];
        if (sel(off, OFS_ESEL))  esel_q  <= wdata_i[NP-1:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (in_bank) begin
      if (sel(off, OFS_IN))    rdata_o[NP-1:0]   = in_sync;
      if (sel(off, OFS_OUT))   rdata_o[NP-1:0]   = dout_q;
      if (sel(off, OFS_MODE))  rdata_o[2*NP-1:0] = mode_q;
      if (sel(off, OFS_PDIS))  rdata_o[NP-1:0]   = pdis_q;
      if (sel(off, OFS_EV))    rdata_o[NP-1:0]   = ev_q;
      if (sel(off, OFS_IEN))   rdata_o[NP-1:0]   = ien_q;
      if (sel(off, OFS_FORCE)) rdata_o[NP-1:0]   = force_q;
      if (sel(off, OFS_ESEL))  rdata_o[NP-1:0]   = esel_q;
    end
  end

  // Pad drive per mode
  for (genvar k = 0; k < NP; k++) begin : g_pad
    always_comb begin
      unique case (drv_mode_e'(mode_q[2*k +: 2]))
        DRV_INPUT: pin_oe_o[k] = 1'b0;
        DRV_PUSH:  pin_oe_o[k] = 1'b1;
        DRV_DRAIN: pin_oe_o[k] = ~dout_q[k];
        DRV_SRC:   pin_oe_o[k] = dout_q[k];
        default:   pin_oe_o[k] = 1'b0;
      endcase
    end
  end

  assign pin_o     = dout_q;
  assign pull_en_o = ~pdis_q;
  assign ev_o      = ev_q;
  assign ien_o     = ien_q;
  assign mode_o    = mode_q;
  assign irq_o     = |(ev_q & ien_q);
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int          NUM_PORTS    = 7,
  parameter int          ADDR_W       = 10,
  parameter logic [6:0]  CORE_VERSION = 7'd5
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [ADDR_W-1:0]                  addr_i,
  input  logic                               we_i,
  input  logic [31:0]                        wdata_i,
  output logic [31:0]                        rdata_o,
  input  logic [NUM_PORTS*PINS_PER_PORT-1:0] pin_i,
  output logic [NUM_PORTS*PINS_PER_PORT-1:0] pin_o,
  output logic [NUM_PORTS*PINS_PER_PORT-1:0] pin_oe_o,
  output logic [NUM_PORTS*PINS_PER_PORT-1:0] pull_en_o,
  output logic [NUM_PORTS-1:0]               irq_o,
  output logic                               clk_req_o
);
  localparam int NP = PINS_PER_PORT;
  localparam int NPINS = NUM_PORTS * NP;

  logic [1:0]                ctrl_q;
  logic [NUM_PORTS-1:0][31:0] port_rd;
  logic [NPINS-1:0]          ev_w, ien_w;
  logic [2*NPINS-1:0]        mode_w;
  logic                      ctrl_sel;

  assign ctrl_sel = addr_i == ADDR_W'(OFS_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ctrl_q <= '0;
    else if (we_i && ctrl_sel) ctrl_q <= wdata_i[1:0];
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    gpio_port #(
      .ADDR_W (ADDR_W),
      .BASE   (p * BANK_STRIDE)
    ) i_port (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .addr_i    (addr_i),
      .we_i      (we_i),
      .wdata_i   (wdata_i[15:0]),
      .pin_i     (pin_i[p*NP +: NP]),
      .rdata_o   (port_rd[p]),
      .pin_o     (pin_o[p*NP +: NP]),
      .pin_oe_o  (pin_oe_o[p*NP +: NP]),
      .pull_en_o (pull_en_o[p*NP +: NP]),
      .ev_o      (ev_w[p*NP +: NP]),
      .ien_o     (ien_w[p*NP +: NP]),
      .mode_o    (mode_w[2*p*NP +: 2*NP]),
      .irq_o     (irq_o[p])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (ctrl_sel) rdata_o[15:0] = {7'(NUM_PORTS), CORE_VERSION, ctrl_q};
    for (int p = 0; p < NUM_PORTS; p++) rdata_o |= port_rd[p];
  end

  assign clk_req_o = ctrl_q[0];
endmodule

// File: rtl/gpio_bank_checker.sv
module gpio_bank_checker #(
  parameter int         NUM_PORTS    = 7,
  parameter int         ADDR_W       = 10,
  parameter logic [6:0] CORE_VERSION = 7'd5
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [ADDR_W-1:0]          addr_i,
  input logic                       we_i,
  input logic [31:0]                rdata_o,
  input logic [NUM_PORTS*8-1:0]     pin_oe_o,
  input logic [NUM_PORTS-1:0]       irq_o,
  input logic [NUM_PORTS*16-1:0]    mode_w,
  input logic [NUM_PORTS*8-1:0]     ev_w,
  input logic [NUM_PORTS*8-1:0]     ien_w
);
  // R7: events only fall after a write cycle
  a_r7_event_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!we_i) |-> (($past(ev_w) & ~ev_w) == '0));

  // R10: read-only identity fields
  a_r10_ctrl_ro: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == '0) |-> (rdata_o[15:2] == {7'(NUM_PORTS), CORE_VERSION}));

  for (genvar i = 0; i < NUM_PORTS*8; i++) begin : g_pin
    // R2: input mode never drives
    a_r2_input_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_w[2*i +: 2] == 2'b00) |-> !pin_oe_o[i]);
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_irq
    // R8: no enable, no interrupt
    a_r8_irq_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ien_w[p*8 +: 8] == '0) |-> !irq_o[p]);
    // R8: enabled pending event raises the line
    a_r8_irq_on_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((ev_w[p*8 +: 8] & ien_w[p*8 +: 8]) != '0) |-> irq_o[p]);
  end
endmodule

bind gpio_bank_ctrl gpio_bank_checker #(
  .NUM_PORTS    (NUM_PORTS),
  .ADDR_W       (ADDR_W),
  .CORE_VERSION (CORE_VERSION)
) i_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .we_i     (we_i),
  .rdata_o  (rdata_o),
  .pin_oe_o (pin_oe_o),
  .irq_o    (irq_o),
  .mode_w   (mode_w),
  .ev_w     (ev_w),
  .ien_w    (ien_w)
);

// File: tb/test_gpio_bank_ctrl.sv
module test_gpio_bank_ctrl;
  localparam int NUM_PORTS = 7;
  localparam int ADDR_W = 10;
  localparam int NPINS = NUM_PORTS * 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [NPINS-1:0] pin_i = '0;
  logic [NPINS-1:0] pin_o, pin_oe_o, pull_en_o;
  logic [NUM_PORTS-1:0] irq_o;
  logic clk_req_o;

  int errors = 0;
  int checks = 0;

  always #2 clk_i = ~clk_i;

  gpio_bank_ctrl #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .CORE_VERSION(7'd5)) i_gpio_bank_ctrl (
    .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i, .rdata_o,
    .pin_i, .pin_o, .pin_oe_o, .pull_en_o, .irq_o, .clk_req_o
  );

  // {addr, write data, expected readback}
  localparam logic [73:0] VEC [0:11] = '{
    {10'h000, 32'hFFFF_FFFF, 32'h0000_0E17},  // R10
    {10'h008, 32'hFFFF_FFAA, 32'h0000_00AA},  // R3
    {10'h00C, 32'hDEAD_1B39, 32'h0000_1B39},  // R2
    {10'h010, 32'h0000_01F0, 32'h0000_00F0},  // R4
    {10'h018, 32'h0000_005A, 32'h0000_005A},  // R8
    {10'h020, 32'h0000_01C3, 32'h0000_00C3},  // R6
    {10'h038, 32'h0000_003C, 32'h0000_003C},  // R1 port 1
    {10'h12C, 32'hFFFF_FFFF, 32'h0000_FFFF},  // R1 port 6
    {10'h030, 32'hFFFF_FFFF, 32'h0000_0000},  // R1 hole
    {10'h150, 32'hFFFF_FFFF, 32'h0000_0000},  // R1 past last bank
    {10'h004, 32'hFFFF_FFFF, 32'h0000_0000},  // R1 input is read-only
    {10'h024, 32'hFFFF_FFFF, 32'h0000_0000}   // R1 unused offset
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(posedge clk_i);
    #1 we_i = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; we_i = 1'b0;
    #1 d = rdata_o;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk_i);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    cyc(2);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    do_reset();

    for (int i = 0; i < 12; i++) begin
      wr(VEC[i][73:64], VEC[i][63:32]);
      rd(VEC[i][73:64], r);
      chk($sformatf("R1/table %0d", i), r, VEC[i][31:0]);
    end

    // R11 reset state
    do_reset();
    rd(10'h008, r); chk("R11 dout", r, 0);
    rd(10'h00C, r); chk("R11 mode", r, 0);
    rd(10'h000, r); chk("R11 ctrl", r, 32'h0000_0E14);
    #1;
    chk("R11 oe", pin_oe_o[31:0], 0);
    chk("R11 pull", pull_en_o[31:0], 32'hFFFF_FFFF);
    chk("R11 irq", 32'(irq_o), 0);
    chk("R10 clk_req low", 32'(clk_req_o), 0);

    // R10 clock request
    wr(10'h000, 32'h1); #1;
    chk("R10 clk_req", 32'(clk_req_o), 1);

    // R2 modes: pin0 push, pin1 drain, pin2 source, pin3 input
    wr(10'h00C, 32'h0039); #1;
    chk("R2 oe data0", 32'(pin_oe_o[3:0]), 32'h3);
    wr(10'h008, 32'h0F); #1;
    chk("R2 oe data1", 32'(pin_oe_o[3:0]), 32'h5);
    chk("R3 pin_o", 32'(pin_o[7:0]), 32'h0F);

    // R4 pull-up
    wr(10'h010, 32'h0F); #1;
    chk("R4 pull", 32'(pull_en_o[7:0]), 32'hF0);

    // R5 sync delay, pin 9 = port 1 bit 1
    @(negedge clk_i); pin_i[9] = 1'b1;
    cyc(1); rd(10'h034, r); chk("R5 after one edge", r, 0);
    rd(10'h034, r); chk("R5 after two edges", r, 32'h02);
    cyc(2);
    rd(10'h044, r); chk("R6 rising ignored in falling mode", r, 0);

    // R6 falling edge latches without enable
    @(negedge clk_i); pin_i[9] = 1'b0;
    cyc(3); #1;
    rd(10'h044, r); chk("R6 falling event", r, 32'h02);
    chk("R8 no irq while disabled", 32'(irq_o), 0);
    wr(10'h048, 32'h02); #1;
    chk("R8 irq port1", 32'(irq_o), 32'h02);

    // R7 clear semantics
    wr(10'h044, 32'h00); rd(10'h044, r); chk("R7 write 0 keeps", r, 32'h02);
    wr(10'h044, 32'h02); rd(10'h044, r); chk("R7 write 1 clears", r, 0);
    #1 chk("R8 irq drops", 32'(irq_o), 0);

    // R6 rising mode
    wr(10'h050, 32'h02);
    @(negedge clk_i); pin_i[9] = 1'b1;
    cyc(3);
    rd(10'h044, r); chk("R6 rising event", r, 32'h02);

    // R9 force on port 2
    wr(10'h07C, 32'h81); cyc(1);
    rd(10'h074, r); chk("R9 forced events", r, 32'h81);
    wr(10'h074, 32'h81); rd(10'h074, r); chk("R7 force wins clear", r, 32'h81);
    wr(10'h07C, 32'h00); wr(10'h074, 32'hFF);
    rd(10'h074, r); chk("R9 force off", r, 0);
    #1 chk("R8 other ports quiet", 32'(irq_o), 32'h02);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule